// File: doc/BRIEF.md
# Sliding-Window Polynomial Remainder Detector

This block watches an unbroken serial bitstream and looks for a valid telegram. It takes the most recent fixed-length span of received bits as a polynomial over GF(2), with the newest bit as the constant term. After every accepted bit it holds the remainder of that span divided by a fixed generator polynomial. A span whose remainder is zero counts as a telegram, and the block raises a one-cycle match pulse for it.

The block never divides the whole span again. The remainder register is advanced once per accepted bit, with a shift and XOR taps set by the generator. The bit that drops out of the span is cancelled by XOR-ing in a constant equal to x^WIN mod g. That constant is worked out at elaboration from the generator parameter. A history shift register supplies the outgoing bit in the same cycle as the incoming one. The remainder is never cleared between spans, so the check slides along the stream one bit at a time.

Top module: `slide_rem_det`

## Requirements
- R1: A synchronous reset clears the remainder, the match output, the bit history and the fill count. Bits received before the reset have no effect on any later remainder.
- R2: In the cycle after each accepted bit (`in_valid` high), `rem_out` equals the GF(2) remainder of the last WIN accepted bits divided by GEN. The newest bit is the coefficient of x^0. Bit positions that have not yet been filled since reset count as zero.
- R3: In a cycle with `in_valid` low, `rem_out` keeps its value and `match` is low in the following cycle.
- R4: `match` is high for exactly the one cycle after an accepted bit when the new remainder is zero and at least WIN bits have been accepted since reset. In every other case it is low.
- R5: Before WIN bits have been accepted since reset, `match` stays low, even when the remainder is zero.
- R6: A 1 bit stops contributing to the remainder once WIN further bits have been accepted. Example: a single 1 followed by WIN zeros gives a zero remainder and a match pulse.
- R7: `rem_out` is GLEN-1 bits wide. Bit k holds the coefficient of x^k. GEN is GLEN bits wide with bit GLEN-1 set, and bit k of GEN is the coefficient of x^k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: `in_bit` is accepted on this edge |
| in_bit | input | 1 | Serial data bit |
| rem_out | output | GLEN-1 | Remainder of the current window modulo GEN |
| match | output | 1 | One-cycle pulse when a full window divides evenly |

## Verification
The bench builds the block with its default parameters: a 1024-bit window and a 76-bit generator. This makes it possible to test the exact fill boundary at bit 1024 and the cancellation of a bit accepted 1024 steps earlier. It also makes it possible to insert a full-length codeword, built in the bench by long division, at a random offset in the stream. After every bit, the bench divides the whole window again and compares the result with the incremental remainder.

// File: rtl/slide_rem_det.sv
`timescale 1ns/1ps
module slide_rem_det #(
  parameter int WIN  = 1024,
  parameter int GLEN = 76,
  parameter logic [GLEN-1:0] GEN = 76'h8000000000000000427
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic [GLEN-2:0]   rem_out,
  output logic              match
);
  localparam int REM_W = GLEN - 1;
  localparam int FW    = $clog2(WIN + 1);

  function automatic logic [REM_W-1:0] xpow_mod();
    logic [REM_W-1:0] r;
    logic             top;
    r = REM_W'(1);
    for (int i = 0; i < WIN; i++) begin
      top = r[REM_W-1];
      r   = {r[REM_W-2:0], 1'b0};
      if (top) r = r ^ GEN[REM_W-1:0];
    end
    return r;
  endfunction

  localparam logic [REM_W-1:0] DROP_K = xpow_mod();

  logic [WIN-1:0]   hist;
  logic [FW-1:0]    fill;
  logic [REM_W-1:0] step, nxt;
  logic             full_nxt;

  assign step     = {rem_out[REM_W-2:0], in_bit} ^ (rem_out[REM_W-1] ? GEN[REM_W-1:0] : '0);
  assign nxt      = step ^ (hist[WIN-1] ? DROP_K : '0);
  assign full_nxt = fill >= FW'(WIN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      fill    <= '0;
      rem_out <= '0;
      match   <= 1'b0;
    end else begin
      match <= 1'b0;
      if (in_valid) begin
        hist    <= {hist[WIN-2:0], in_bit};
        rem_out <= nxt;
        match   <= full_nxt && (nxt == '0);
        if (fill != FW'(WIN)) fill <= fill + 1'b1;
      end
    end
  end
endmodule

module slide_rem_det_chk #(
  parameter int WIN   = 1024,
  parameter int REM_W = 75
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [REM_W-1:0] rem_out,
  input logic             match
);
  localparam int FW = $clog2(WIN + 1);
  logic [FW-1:0] cnt;
  logic          rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) cnt <= '0;
    else if (in_valid && cnt != FW'(WIN)) cnt <= cnt + 1'b1;
    if (rst_q) AST_RESET_CLEAR: assert (rem_out == '0 && !match); // R1
  end

  AST_IDLE_HOLD:   assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(rem_out)); // R3
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (rst) !in_valid |=> !match); // R3
  AST_MATCH_ZERO:  assert property (@(posedge clk) disable iff (rst) match |-> rem_out == '0); // R4
  AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (rst) (in_valid && cnt < FW'(WIN - 1)) |=> !match); // R5
endmodule

bind slide_rem_det slide_rem_det_chk #(.WIN(WIN), .REM_W(REM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .rem_out(rem_out), .match(match)
);

// File: tb/slide_rem_det_tb.sv
`timescale 1ns/1ps
module slide_rem_det_tb;
  localparam int WIN  = 1024;
  localparam int GLEN = 76;
  localparam int RW   = GLEN - 1;
  localparam logic [GLEN-1:0] GEN = 76'h8000000000000000427;

  // segment table: {mode[3:0], length[11:0]}; 0 random, 1 ones, 2 zeros, 3 alternating, 4 idle
  localparam int NSEG = 7;
  localparam logic [15:0] SEGS [NSEG] = '{
    {4'd0, 12'd300}, {4'd1, 12'd200}, {4'd4, 12'd6}, {4'd2, 12'd100},
    {4'd3, 12'd700}, {4'd4, 12'd3},   {4'd0, 12'd900}
  };

  logic clk = 0, rst = 1, in_valid = 0, in_bit = 0;
  logic [RW-1:0] rem_out;
  logic match;
  int checks = 0, errors = 0;
  logic done = 0;

  logic [WIN-1:0] win_m = '0;
  int unsigned seen = 0;
  logic [RW-1:0] exp_rem = '0;

  slide_rem_det #(.WIN(WIN), .GLEN(GLEN), .GEN(GEN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .rem_out(rem_out), .match(match)
  );

  always #10 clk = ~clk;

  function automatic logic [RW-1:0] full_div(input logic [WIN-1:0] w);
    logic [RW-1:0] r = '0;
    logic top;
    for (int i = WIN - 1; i >= 0; i--) begin
      top = r[RW-1];
      r = {r[RW-2:0], w[i]};
      if (top) r = r ^ GEN[RW-1:0];
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    logic exp_m;
    @(negedge clk);
    in_valid = 1; in_bit = b;
    @(posedge clk); #1;
    win_m = {win_m[WIN-2:0], b};
    if (seen < WIN) seen++;
    exp_rem = full_div(win_m);
    exp_m = (seen >= WIN) && (exp_rem == '0);
    chk(rem_out == exp_rem, "R2 remainder", rem_out, exp_rem);
    chk(match == exp_m, "R4 match", RW'(match), RW'(exp_m));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_bit = 1'($urandom);
    @(posedge clk); #1;
    chk(rem_out == exp_rem, "R3 idle hold", rem_out, exp_rem);
    chk(!match, "R3 idle match", RW'(match), '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    @(posedge clk); #1;
    rst = 0;
    win_m = '0; seen = 0; exp_rem = '0;
    chk(rem_out == '0, "R1 reset remainder", rem_out, '0);
    chk(!match, "R1 reset match", RW'(match), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WIN-1:0] cw;
    repeat (2) @(posedge clk);
    do_reset();

    // R5: all-zero window, remainder zero, no match until WIN bits
    for (int i = 0; i < WIN - 1; i++) send(1'b0);
    chk(!match, "R5 no match before full window", RW'(match), '0);
    send(1'b0);
    chk(match, "R5 match at exactly WIN bits", RW'(match), RW'(1));

    // R6: single one leaves the window after WIN further bits
    send(1'b1);
    for (int i = 0; i < WIN - 1; i++) send(1'b0);
    chk(rem_out != '0, "R6 bit still inside window", rem_out, exp_rem);
    send(1'b0);
    chk(rem_out == '0 && match, "R6 outgoing bit cancelled", rem_out, '0);

    // table walk
    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < int'(SEGS[s][11:0]); k++) begin
        case (SEGS[s][15:12])
          4'd0: send(1'($urandom));
          4'd1: send(1'b1);
          4'd2: send(1'b0);
          4'd3: send(1'(k));
          default: idle();
        endcase
      end
    end

    // R4: codeword at a random offset
    cw = '0;
    for (int i = RW; i < WIN; i++) cw[i] = 1'($urandom);
    cw[RW-1:0] = full_div(cw);
    for (int i = 0; i < 50 + int'($urandom % 300); i++) send(1'($urandom));
    for (int i = WIN - 1; i >= 0; i--) send(cw[i]);
    chk(rem_out == '0 && match, "R4 codeword detected", rem_out, '0);
    send(1'b1);
    chk(!match, "R4 single-cycle pulse", RW'(match), '0);
    idle();

    // R1: reset mid-stream discards history
    for (int i = 0; i < 40; i++) send(1'b1);
    do_reset();
    for (int i = 0; i < 60; i++) send(1'b1);
    chk(rem_out == full_div({{(WIN-60){1'b0}}, {60{1'b1}}}), "R1 history cleared", rem_out, exp_rem);

    // R7: remainder width follows GLEN
    chk($bits(rem_out) == GLEN - 1, "R7 remainder width", RW'($bits(rem_out)), RW'(GLEN - 1));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule